// File: doc/BRIEF.md
# Floating-Point Exception Trap Arbiter

After each floating-point operation, this block receives the exception flags that the operation raised. It decides whether the operation must trap. It also keeps a sticky status word that collects the exceptions seen since the word was last cleared. The block does no arithmetic. It only combines the raised flags with an ignore mask, an enable mask and a software-completion mode bit.

The two trap modes do their steps in a different order:

- **Plain mode.** Every raised flag is first merged into the sticky status. The ignored flags are then removed, and any flag that remains causes a trap.
- **Software-completion mode.** The ignored flags are removed before anything else, so they never reach the sticky status. A trap fires only when a remaining flag is also enabled.

When a trap fires, the block reports three things:

- a one-cycle pulse;
- a summary of the trapping exceptions, tagged with the mode;
- a one-hot mask that marks the destination register.

Software can overwrite the sticky status through a write port or clear it with a synchronous clear.

Top module: `fpx_trap_arbiter`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, all outputs are zero.
- R2: In plain mode (`swc_mode`=0), an event merges every raised flag into `sticky`, including the ignored ones. The flag bit order is bit0 invalid, bit1 divide-by-zero, bit2 overflow, bit3 underflow, bit4 inexact, bit5 integer overflow.
- R3: In plain mode, a trap fires exactly when `evt_flags & ~ignore_mask` is nonzero, whatever `enable_mask` holds. The summary then holds those remaining flags in bits 5:0, with bit6 equal to 0.
- R4: In software-completion mode (`swc_mode`=1), only `evt_flags & ~ignore_mask` is merged into `sticky`.
- R5: In software-completion mode, a trap fires exactly when `evt_flags & ~ignore_mask & enable_mask` is nonzero. The summary then holds that product in bits 5:0, with bit6 (the software-completion bit) equal to 1.
- R6: On a trap, `trap_regmask` has exactly one bit set, at position `dest_reg`.
- R7: An event whose flags are all zero, or a cycle with `evt_valid` low, leaves every output unchanged apart from the pulse, and raises no trap.
- R8: `trap_pulse` is high for exactly the cycle after a trapping event. `trap_summary` and `trap_regmask` hold their values until the next trap.
- R9: `clr_sticky` zeroes `sticky` in the next cycle. It takes priority over the write port and over any event.
- R10: When `sw_wr_en` is high, `sticky` takes `sw_wr_data` in the next cycle. The write takes priority over an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Marks a cycle that carries an operation's flags |
| evt_flags | input | 6 | Raised exception flags |
| ignore_mask | input | 6 | Flags to drop from trapping |
| enable_mask | input | 6 | Enabled exceptions (software-completion mode only) |
| swc_mode | input | 1 | Selects software-completion mode |
| dest_reg | input | 5 | Destination register number of the operation |
| clr_sticky | input | 1 | Synchronous clear of the sticky status |
| sw_wr_en | input | 1 | Software write strobe for the sticky status |
| sw_wr_data | input | 6 | Value written to the sticky status |
| trap_pulse | output | 1 | One-cycle trap indication |
| trap_summary | output | 7 | Trapping exceptions; bit6 is the software-completion tag |
| trap_regmask | output | 32 | One-hot destination register mask |
| sticky | output | 6 | Sticky exception status |

## Verification
The temporal assertions rely on the inputs being sampled only at rising edges, and on `dest_reg` always naming a register inside the mask width. The bench therefore changes every input on the falling edge and draws `dest_reg` from its full 5-bit range. Some checks read `$past` of the masks and the mode bit in the cycle after an event. The bench keeps those inputs steady across each event, and in its random phase it lets them change only together with a fresh event. Clear, write and event strobes are made to overlap on purpose, so that the priority order is exercised rather than avoided.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int EXC_N = 6;

    localparam int EXC_INV = 0;
    localparam int EXC_DZE = 1;
    localparam int EXC_OVF = 2;
    localparam int EXC_UNF = 3;
    localparam int EXC_INE = 4;
    localparam int EXC_IOV = 5;

    typedef logic [EXC_N-1:0] exc_vec_t;

    typedef struct packed {
        logic     swc;
        exc_vec_t exc;
    } summary_t;

    typedef struct packed {
        logic     fire;
        exc_vec_t sticky_add;
        summary_t summ;
    } decision_t;

    function automatic exc_vec_t exc_strip(exc_vec_t flags, exc_vec_t ign);
        return flags & ~ign;
    endfunction

endpackage

// File: rtl/fpx_decide.sv
module fpx_decide
    import fpx_pkg::*;
(
    input  logic      valid,
    input  exc_vec_t  flags,
    input  exc_vec_t  ignore_mask,
    input  exc_vec_t  enable_mask,
    input  logic      swc_mode,
    output decision_t dec
);
    exc_vec_t  kept;
    exc_vec_t  gated;
    logic      active;

    always_comb begin
        active = valid && (flags != '0);
        kept   = exc_strip(flags, ignore_mask);
        gated  = kept & enable_mask;
        dec    = '0;
        if (active) begin
            if (swc_mode) begin
                dec.sticky_add = kept;
                dec.fire       = (gated != '0);
                dec.summ.swc   = 1'b1;
                dec.summ.exc   = gated;
            end else begin
                dec.sticky_add = flags;
                dec.fire       = (kept != '0);
                dec.summ.swc   = 1'b0;
                dec.summ.exc   = kept;
            end
        end
    end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     wr_en,
    input  exc_vec_t wr_data,
    input  exc_vec_t add,
    output exc_vec_t status
);
    exc_vec_t status_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            status_q <= '0;
        else if (wr_en)
            status_q <= wr_data;
        else
            status_q <= status_q | add;
    end

    assign status = status_q;

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> status_q == '0);

    assert_write_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !clr) |=> status_q == $past(wr_data));

    assert_monotone_R2: assert property (@(posedge clk) disable iff (rst)
        (!clr && !wr_en) |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/fpx_onehot.sv
module fpx_onehot #(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [IDX_W-1:0]    idx,
    output logic [NUM_REGS-1:0] mask
);
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_bit
        assign mask[i] = (idx == IDX_W'(i));
    end
endmodule

// File: rtl/fpx_trap_arbiter.sv
module fpx_trap_arbiter
    import fpx_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int SUM_W   = EXC_N + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                evt_valid,
    input  logic [EXC_N-1:0]    evt_flags,
    input  logic [EXC_N-1:0]    ignore_mask,
    input  logic [EXC_N-1:0]    enable_mask,
    input  logic                swc_mode,
    input  logic [IDX_W-1:0]    dest_reg,
    input  logic                clr_sticky,
    input  logic                sw_wr_en,
    input  logic [EXC_N-1:0]    sw_wr_data,
    output logic                trap_pulse,
    output logic [SUM_W-1:0]    trap_summary,
    output logic [NUM_REGS-1:0] trap_regmask,
    output logic [EXC_N-1:0]    sticky
);
    decision_t             dec;
    logic [NUM_REGS-1:0]   dest_mask;
    logic                  pulse_q;
    summary_t              summ_q;
    logic [NUM_REGS-1:0]   mask_q;

    fpx_decide u_decide (
        .valid       (evt_valid),
        .flags       (evt_flags),
        .ignore_mask (ignore_mask),
        .enable_mask (enable_mask),
        .swc_mode    (swc_mode),
        .dec         (dec)
    );

    fpx_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_sticky),
        .wr_en   (sw_wr_en),
        .wr_data (sw_wr_data),
        .add     (dec.sticky_add),
        .status  (sticky)
    );

    fpx_onehot #(.NUM_REGS(NUM_REGS)) u_onehot (
        .idx  (dest_reg),
        .mask (dest_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= 1'b0;
            summ_q  <= '0;
            mask_q  <= '0;
        end else begin
            pulse_q <= dec.fire;
            if (dec.fire) begin
                summ_q <= dec.summ;
                mask_q <= dest_mask;
            end
        end
    end

    assign trap_pulse   = pulse_q;
    assign trap_summary = summ_q;
    assign trap_regmask = mask_q;

    assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $past(evt_valid));

    assert_regmask_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> ($countones(trap_regmask) == 1));

    assert_plain_summary_R3: assert property (@(posedge clk) disable iff (rst)
        (trap_pulse && !$past(swc_mode)) |->
            (trap_summary == {1'b0, $past(evt_flags) & ~$past(ignore_mask)}));

    assert_swc_gated_R5: assert property (@(posedge clk) disable iff (rst)
        (trap_pulse && $past(swc_mode)) |->
            (trap_summary[EXC_N] && ((trap_summary[EXC_N-1:0] & ~$past(enable_mask)) == '0)));

    assert_zero_noop_R7: assert property (@(posedge clk) disable iff (rst)
        (evt_flags == '0 && !clr_sticky && !sw_wr_en) |=>
            (!trap_pulse && $stable(sticky) && $stable(trap_summary)));
endmodule

// File: tb/fpx_trap_arbiter_tb.sv
module fpx_trap_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [5:0]  evt_flags = '0;
    logic [5:0]  ignore_mask = '0;
    logic [5:0]  enable_mask = '0;
    logic        swc_mode = 1'b0;
    logic [4:0]  dest_reg = '0;
    logic        clr_sticky = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [5:0]  sw_wr_data = '0;
    logic        trap_pulse;
    logic [6:0]  trap_summary;
    logic [31:0] trap_regmask;
    logic [5:0]  sticky;

    int n_checks = 0;
    int n_fail   = 0;

    int          m_sticky = 0;
    int          m_pulse = 0;
    int          m_summary = 0;
    longint      m_mask = 0;

    always #5 clk = ~clk;

    fpx_trap_arbiter u_dut (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_flags(evt_flags),
        .ignore_mask(ignore_mask), .enable_mask(enable_mask), .swc_mode(swc_mode),
        .dest_reg(dest_reg), .clr_sticky(clr_sticky), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .trap_pulse(trap_pulse), .trap_summary(trap_summary),
        .trap_regmask(trap_regmask), .sticky(sticky)
    );

    task automatic check(string tag, string what, longint got, longint exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    task automatic tick(string tag);
        int f, ig, en, rem, add, tr, summ;
        f = evt_flags; ig = ignore_mask; en = enable_mask;
        @(posedge clk);
        add = 0; tr = 0; summ = 0;
        if (evt_valid && f != 0) begin
            rem = f & ~ig & 63;
            if (swc_mode) begin
                add = rem;
                tr = ((rem & en) != 0) ? 1 : 0;
                summ = 64 + (rem & en);
            end else begin
                add = f;
                tr = (rem != 0) ? 1 : 0;
                summ = rem;
            end
        end
        if (rst) begin
            m_sticky = 0; m_pulse = 0; m_summary = 0; m_mask = 0;
        end else begin
            if (clr_sticky) m_sticky = 0;
            else if (sw_wr_en) m_sticky = sw_wr_data;
            else m_sticky = m_sticky | add;
            m_pulse = tr;
            if (tr != 0) begin
                m_summary = summ;
                m_mask = longint'(1) << dest_reg;
            end
        end
        @(negedge clk);
        check(tag, "trap_pulse", trap_pulse, m_pulse);
        check(tag, "trap_summary", trap_summary, m_summary);
        check(tag, "trap_regmask", trap_regmask, m_mask);
        check(tag, "sticky", sticky, m_sticky);
    endtask

    task automatic event_op(logic [5:0] f, logic [5:0] ig, logic [5:0] en,
                            logic s, logic [4:0] d, string tag);
        evt_valid = 1'b1; evt_flags = f; ignore_mask = ig; enable_mask = en;
        swc_mode = s; dest_reg = d;
        tick(tag);
        evt_valid = 1'b0; evt_flags = '0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 1'b0;
        tick("R1");
        // R2 R3: plain mode, ignored invalid still goes sticky, trap on rest
        event_op(6'b010101, 6'b000001, 6'b000000, 1'b0, 5'd3, "R2");
        tick("R8");
        // R3: everything ignored -> no trap, enable has no effect
        event_op(6'b000100, 6'b000100, 6'b111111, 1'b0, 5'd7, "R3");
        event_op(6'b100000, 6'b000000, 6'b000000, 1'b0, 5'd31, "R3");
        // clear before software-completion tests
        clr_sticky = 1'b1; tick("R9"); clr_sticky = 1'b0;
        // R4 R5: ignored bits never sticky, enable gates the trap
        event_op(6'b001010, 6'b000010, 6'b001000, 1'b1, 5'd0, "R4");
        event_op(6'b000011, 6'b000001, 6'b000000, 1'b1, 5'd9, "R5");
        event_op(6'b110000, 6'b110000, 6'b111111, 1'b1, 5'd9, "R4");
        event_op(6'b111111, 6'b000000, 6'b010001, 1'b1, 5'd17, "R5");
        // R6: destination boundaries
        event_op(6'b000001, 6'b000000, 6'b000000, 1'b0, 5'd0, "R6");
        event_op(6'b000001, 6'b000000, 6'b000000, 1'b0, 5'd31, "R6");
        // R7: zero flags with valid, and flags without valid
        event_op(6'b000000, 6'b000000, 6'b111111, 1'b1, 5'd5, "R7");
        evt_flags = 6'b111111; dest_reg = 5'd12; tick("R7"); evt_flags = '0;
        tick("R8");
        // R8: back-to-back traps
        evt_valid = 1'b1; swc_mode = 1'b0; ignore_mask = '0;
        evt_flags = 6'b000100; dest_reg = 5'd4; tick("R8");
        evt_flags = 6'b001000; dest_reg = 5'd20; tick("R8");
        evt_valid = 1'b0; evt_flags = '0;
        tick("R8"); tick("R8");
        // R10: write beats a same-cycle event
        sw_wr_en = 1'b1; sw_wr_data = 6'b000010;
        event_op(6'b110000, 6'b000000, 6'b000000, 1'b0, 5'd2, "R10");
        sw_wr_en = 1'b0;
        // R9: clear beats write and event
        clr_sticky = 1'b1; sw_wr_en = 1'b1; sw_wr_data = 6'b111111;
        event_op(6'b000111, 6'b000000, 6'b000000, 1'b0, 5'd6, "R9");
        clr_sticky = 1'b0; sw_wr_en = 1'b0;
        tick("R9");
        // mixed random traffic
        for (int i = 0; i < 400; i++) begin
            logic s;
            s = 1'($urandom);
            evt_valid = 1'($urandom);
            evt_flags = 6'($urandom) & 6'($urandom);
            ignore_mask = 6'($urandom);
            enable_mask = 6'($urandom);
            swc_mode = s;
            dest_reg = 5'($urandom);
            clr_sticky = ($urandom % 23) == 0;
            sw_wr_en = ($urandom % 17) == 0;
            sw_wr_data = 6'($urandom);
            tick(s ? "R5" : "R3");
        end
        evt_valid = 1'b0; clr_sticky = 1'b0; sw_wr_en = 1'b0;
        tick("R7");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule